// File: doc/BRIEF.md
# Stepped Instruction-Cycle Core Slice

This block is a small byte-wide processor slice that runs each instruction over six one-clock steps. It holds the step counter, the instruction register, the instruction address register (IAR), the memory address register (MAR), an accumulator, a load-only temporary register feeding the second ALU operand, and four general registers. Memory is read through a byte-wide port. The MAR drives the address, and read data must be valid in the same cycle.

Whenever no ALU instruction is in its operate step, the ALU select lines rest at the add code. The second operand can also be forced to one by a constant-one path. The fetch uses these two features to advance the IAR. The immediate-load instruction uses them again to step the IAR past its inline data byte, so no separate incrementer exists. Register contents are brought out on debug ports.

Top module: `step_core`

## Requirements
- R1: Each instruction takes exactly six clock cycles. `dbg_step` counts 0 to 5 and then returns to 0.
- R2: After the second step, `dbg_ir` holds the memory byte at the instruction's address. After the third step, `dbg_iar` holds that address plus one.
- R3: The IAR changes only at the end of the third step. For the immediate-load instruction it also changes at the end of the sixth step.
- R4: A byte with bit 7 set is an ALU instruction. Bits 6:4 select the operation, bits 3:2 select the register for operand A, and bits 1:0 select the register for operand B, which is also the destination. The result is in `dbg_acc` after the fifth step and in the destination register after the sixth step.
- R5: The operation codes are: 000 A+B modulo 256, 001 A shifted right by one, 010 A shifted left by one, 011 bitwise NOT A, 100 A AND B, 101 A OR B, 110 A XOR B, and 111 compare, which places A XOR B in the accumulator.
- R6: A byte whose top nibble is 0010 is an immediate load. After the fourth step the accumulator holds the instruction address plus two, produced by the default add with the constant one. After the fifth step the register named by bits 1:0 holds the next memory byte. After the sixth step the IAR holds the instruction address plus two.
- R7: The compare operation (code 111) writes no general register.
- R8: Any other opcode writes no general register. It leaves the IAR and the accumulator both at the instruction address plus one.
- R9: While reset is asserted, all registers, the IAR, the MAR and the step counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | W | Memory address, driven by the MAR |
| mem_rdata | input | W | Memory read data for `mem_addr` |
| dbg_step | output | 3 | Current step, 0 to 5 |
| dbg_ir | output | W | Instruction register |
| dbg_iar | output | W | Instruction address register |
| dbg_acc | output | W | Accumulator |
| dbg_regs | output | 4*W | General registers; register k occupies bits k*W+W-1 to k*W |

## Verification
The bench builds the core with the default width of 8. This makes the whole 256-byte address space and modulo-256 wrap of the sums cheap to model. It sweeps all eight ALU codes across all sixteen operand-register pairs, in several rounds of register values that include 0x00, 0xFF, 0x80 and 0x01. Every program also contains immediate loads to all four registers and unimplemented opcodes. Inside each immediate load the bench samples the mid-instruction steps, which exposes the cycle in which the default add and the data-byte skip take effect.

// File: rtl/step_core.sv
module step_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [W-1:0]   mem_addr,
  input  logic [W-1:0]   mem_rdata,
  output logic [2:0]     dbg_step,
  output logic [W-1:0]   dbg_ir,
  output logic [W-1:0]   dbg_iar,
  output logic [W-1:0]   dbg_acc,
  output logic [4*W-1:0] dbg_regs
);
  localparam logic [2:0] LAST = 3'd5;
  localparam logic [2:0] CMP  = 3'b111;

  logic [2:0]   step;
  logic [W-1:0] ir, iar, mar, acc, tmp;
  logic [W-1:0] gr [4];
  logic [W-1:0] bus, alu_b, alu_y;
  logic [2:0]   op;

  wire is_alu  = ir[W-1];
  wire is_data = (ir[W-1:W-4] == 4'b0010);
  wire [1:0] ra = ir[3:2];
  wire [1:0] rb = ir[1:0];
  wire bus1 = (step == 3'd0) || (step == 3'd3 && is_data);

  assign op    = (is_alu && step == 3'd4) ? ir[W-2:W-4] : 3'b000;
  assign alu_b = bus1 ? W'(1) : tmp;

  always_comb begin
    case (step)
      3'd0:    bus = iar;
      3'd3:    bus = is_data ? iar : gr[rb];
      3'd4:    bus = is_data ? mem_rdata : gr[ra];
      default: bus = acc;
    endcase
  end

  always_comb begin
    case (op)
      3'd0:    alu_y = bus + alu_b;
      3'd1:    alu_y = bus >> 1;
      3'd2:    alu_y = bus << 1;
      3'd3:    alu_y = ~bus;
      3'd4:    alu_y = bus & alu_b;
      3'd5:    alu_y = bus | alu_b;
      default: alu_y = bus ^ alu_b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      ir   <= '0;
      iar  <= '0;
      mar  <= '0;
      acc  <= '0;
      tmp  <= '0;
      for (int i = 0; i < 4; i++) gr[i] <= '0;
    end else begin
      step <= (step == LAST) ? 3'd0 : step + 3'd1;
      case (step)
        3'd0: begin
          mar <= bus;
          acc <= alu_y;
        end
        3'd1: ir  <= mem_rdata;
        3'd2: iar <= bus;
        3'd3: begin
          if (is_data) begin
            mar <= bus;
            acc <= alu_y;
          end else if (is_alu) begin
            tmp <= bus;
          end
        end
        3'd4: begin
          if (is_data) gr[rb] <= bus;
          else if (is_alu) acc <= alu_y;
        end
        default: begin
          if (is_data) iar <= bus;
          else if (is_alu && ir[W-2:W-4] != CMP) gr[rb] <= bus;
        end
      endcase
    end
  end

  assign mem_addr = mar;
  assign dbg_step = step;
  assign dbg_ir   = ir;
  assign dbg_iar  = iar;
  assign dbg_acc  = acc;

  for (genvar k = 0; k < 4; k++) begin : g_dbg
    assign dbg_regs[k*W +: W] = gr[k];
  end

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) step == LAST |=> step == 3'd0); // R1
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n) step != LAST |=> step == $past(step) + 3'd1); // R1
  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) step == 3'd1 |=> ir == $past(mem_rdata)); // R2
  AST_IAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (step == 3'd0 || step == 3'd1 || step == 3'd3 || step == 3'd4) |=> $stable(iar)); // R3
  AST_DATA_SKIP: assert property (@(posedge clk) disable iff (!rst_n) (step == LAST && is_data) |=> iar == $past(iar) + W'(1)); // R6
  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n) (step == LAST && is_alu && ir[W-2:W-4] == CMP) |=> $stable(dbg_regs)); // R7
  AST_NOP_REGS: assert property (@(posedge clk) disable iff (!rst_n) (step >= 3'd3 && !is_alu && !is_data) |=> $stable(dbg_regs)); // R8
endmodule

// File: tb/step_core_bench.sv
module step_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_rdata;
  logic [2:0] dbg_step;
  logic [7:0] dbg_ir, dbg_iar, dbg_acc;
  logic [31:0] dbg_regs;
  logic [7:0] mem [256];
  logic [7:0] mr [4];
  logic [7:0] m_iar, m_acc;
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  step_core #(.W(8)) u_step_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dbg_step(dbg_step), .dbg_ir(dbg_ir), .dbg_iar(dbg_iar),
    .dbg_acc(dbg_acc), .dbg_regs(dbg_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a >> 1;
      3'd2: return a << 1;
      3'd3: return ~a;
      3'd4: return a & b;
      3'd5: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [31:0] pack_regs();
    return {mr[3], mr[2], mr[1], mr[0]};
  endfunction

  task automatic run_instr();
    logic [7:0] pc, code, res, a, b;
    pc = m_iar;
    code = mem[pc];
    repeat (2) @(negedge clk);
    chk("R2 ir after fetch", 32'(dbg_ir), 32'(code));
    @(negedge clk);
    chk("R2 iar after step three", 32'(dbg_iar), 32'(8'(pc + 8'd1)));
    if (code[7]) begin
      a = mr[code[3:2]];
      b = mr[code[1:0]];
      res = ref_alu(code[6:4], a, b);
      repeat (2) @(negedge clk);
      chk("R4 R5 acc after step five", 32'(dbg_acc), 32'(res));
      @(negedge clk);
      if (code[6:4] != 3'b111) mr[code[1:0]] = res;
      else chk("R7 compare keeps regs", dbg_regs, pack_regs());
      m_acc = res;
      m_iar = pc + 8'd1;
      chk("R3 R4 iar after alu", 32'(dbg_iar), 32'(m_iar));
    end else if (code[7:4] == 4'b0010) begin
      @(negedge clk);
      chk("R6 acc two past after step four", 32'(dbg_acc), 32'(8'(pc + 8'd2)));
      @(negedge clk);
      mr[code[1:0]] = mem[8'(pc + 8'd1)];
      chk("R6 dest loaded after step five", dbg_regs, pack_regs());
      chk("R3 iar held in step five", 32'(dbg_iar), 32'(8'(pc + 8'd1)));
      @(negedge clk);
      m_acc = pc + 8'd2;
      m_iar = pc + 8'd2;
      chk("R6 iar skips data byte", 32'(dbg_iar), 32'(m_iar));
    end else begin
      repeat (3) @(negedge clk);
      m_acc = pc + 8'd1;
      m_iar = pc + 8'd1;
      chk("R8 other opcode iar", 32'(dbg_iar), 32'(m_iar));
      chk("R8 other opcode acc", 32'(dbg_acc), 32'(m_acc));
    end
    chk("R1 step wraps", 32'(dbg_step), 32'd0);
    chk("R4 R6 R8 register file", dbg_regs, pack_regs());
  endtask

  task automatic run_program(input int op, input int round);
    int n;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int r = 0; r < 4; r++) begin
      mem[2*r]   = 8'h20 | 8'(r);
      mem[2*r+1] = (round == 0) ? ((r == 0) ? 8'h00 : (r == 1) ? 8'hFF : (r == 2) ? 8'h80 : 8'h01)
                                : 8'(op*37 + round*91 + r*53 + 11);
    end
    n = 8;
    for (int ra = 0; ra < 4; ra++)
      for (int rb = 0; rb < 4; rb++) begin
        mem[n] = 8'h80 | 8'(op << 4) | 8'(ra << 2) | 8'(rb);
        n++;
      end
    mem[n] = 8'h00; mem[n+1] = 8'h50; mem[n+2] = 8'h7F;
    chk("R9 reset step", 32'(dbg_step), 32'd0);
    chk("R9 reset regs", dbg_regs, 32'd0);
    chk("R9 reset iar acc ir mar", {dbg_iar, dbg_acc, dbg_ir, mem_addr}, 32'd0);
    for (int r = 0; r < 4; r++) mr[r] = 8'h00;
    m_iar = 8'h00;
    m_acc = 8'h00;
    rst_n = 1'b1;
    for (int k = 0; k < 23; k++) run_instr();
  endtask

  initial begin
    for (int op = 0; op < 8; op++)
      for (int round = 0; round < 3; round++)
        run_program(op, round);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule